// File: doc/BRIEF.md
# Serial Command Word Receiver

This block sits on the peripheral side of a four-wire serial link and turns fixed-length command words from a host into register updates. The host lowers chip select, shifts sixteen bits most significant first with a clock that idles low, and raises chip select again. Every word is its own frame. The block runs on a system clock that is much faster than the serial clock. All three serial inputs are brought into the system domain through flop chains, and all edge detection happens there.

Each accepted word is split into a 4-bit opcode and a 12-bit payload. One opcode loads a 12-bit mode register. A second opcode sets or clears a single trace flag. Every other opcode is passed on as a one-cycle strobe that carries the opcode and the payload, for logic outside the block to act on. The block drops any frame whose bit count at chip-select release is not exactly sixteen, and no state changes.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, `mode_q` is 0, `trace_en` is 0 and `cmd_strobe` is 0.
- R2: Bits are captured on rising edges of `spi_sck` while `spi_cs_n` is low, first bit received is word bit 15. The opcode is word bits [15:12] and the payload is word bits [11:0].
- R3: A frame whose number of rising clock edges at the rise of `spi_cs_n` differs from 16 (including 0) is dropped. `mode_q`, `trace_en` and `cmd_strobe` keep their values.
- R4: A full frame with opcode `OP_SET_MODE` (default 4'h1) loads its payload into `mode_q`. This happens within six system clocks of the rise of `spi_cs_n`.
- R5: A full frame with opcode `OP_TRACE` (default 4'h2) sets `trace_en` to payload bit 0. This happens within six system clocks of the rise of `spi_cs_n`.
- R6: A full frame with any other opcode pulses `cmd_strobe` for exactly one system clock. While the strobe is high, `cmd_code` shows the opcode and `cmd_data` shows the payload. `mode_q` and `trace_en` do not change.
- R7: Rising edges of `spi_sck` while `spi_cs_n` is high are ignored and are not counted toward the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame select from host, low during a frame |
| spi_sck | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| mode_q | output | 12 | Mode register |
| trace_en | output | 1 | Trace flag |
| cmd_strobe | output | 1 | One-cycle pulse for a pass-through opcode |
| cmd_code | output | 4 | Opcode of the last pass-through frame |
| cmd_data | output | 12 | Payload of the last pass-through frame |

## Verification
The hardest case to reach from the ports is a frame with the wrong length whose last sixteen bits still form a valid word. This is where a receiver that only looks at its shift register would wrongly accept the frame. The stimulus sends frames of several lengths cut from a repeated pattern of valid words, both a mode-load word and a pass-through word. It then checks that the mode register stays at a known value and that the strobe count does not move. Stray serial clock edges sent while chip select is high are followed directly by a full frame. A receiver that counted those edges would reject that frame.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_MODE  = 2'd1,
      ACT_TRACE = 2'd2,
      ACT_PASS  = 2'd3
   } cmd_act_e;

   function automatic cmd_act_e classify_op(input logic [7:0] op,
                                            input logic [7:0] op_mode,
                                            input logic [7:0] op_trace);
      if (op == op_mode)       return ACT_MODE;
      else if (op == op_trace) return ACT_TRACE;
      else                     return ACT_PASS;
   endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
`timescale 1ns/1ps
module spi_cmd_sync #(
   parameter int                WIDTH   = 3,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/spi_cmd_framer.sv
`timescale 1ns/1ps
module spi_cmd_framer #(
   parameter int FRAME_W = 16,
   localparam int CNT_MAX = FRAME_W + 1,
   localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n_s,
   input  logic               sck_s,
   input  logic               mosi_s,
   output logic               frm_valid,
   output logic [FRAME_W-1:0] frm_word,
   output logic [CNT_W-1:0]   bit_cnt
);

   logic               cs_n_d;
   logic               sck_d;
   logic [FRAME_W-1:0] shreg;
   logic               sck_rise;
   logic               cs_release;
   logic               full_count;

   assign sck_rise   = sck_s & ~sck_d;
   assign cs_release = cs_n_s & ~cs_n_d;
   assign full_count = (bit_cnt == CNT_W'(FRAME_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n_d    <= 1'b1;
         sck_d     <= 1'b0;
         shreg     <= '0;
         bit_cnt   <= '0;
         frm_valid <= 1'b0;
         frm_word  <= '0;
      end else begin
         cs_n_d    <= cs_n_s;
         sck_d     <= sck_s;
         frm_valid <= 1'b0;
         if (cs_n_s) begin
            if (cs_release && full_count) begin
               frm_valid <= 1'b1;
               frm_word  <= shreg;
            end
            bit_cnt <= '0;
         end else if (sck_rise) begin
            shreg <= {shreg[FRAME_W-2:0], mosi_s};
            if (bit_cnt != CNT_W'(CNT_MAX))
               bit_cnt <= bit_cnt + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/spi_cmd_decode.sv
`timescale 1ns/1ps
module spi_cmd_decode
   import spi_cmd_pkg::*;
#(
   parameter int                CMD_W     = 4,
   parameter int                DATA_W    = 12,
   parameter logic [CMD_W-1:0]  OP_SET_MODE = 4'h1,
   parameter logic [CMD_W-1:0]  OP_TRACE    = 4'h2,
   parameter logic [DATA_W-1:0] MODE_RST    = '0,
   localparam int FRAME_W = CMD_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frm_valid,
   input  logic [FRAME_W-1:0] frm_word,
   output logic [DATA_W-1:0]  mode_q,
   output logic               trace_en,
   output logic               cmd_strobe,
   output logic [CMD_W-1:0]   cmd_code,
   output logic [DATA_W-1:0]  cmd_data
);

   logic [CMD_W-1:0]  op;
   logic [DATA_W-1:0] payload;
   cmd_act_e          act;

   assign op      = frm_word[FRAME_W-1 -: CMD_W];
   assign payload = frm_word[DATA_W-1:0];

   always_comb begin
      if (frm_valid)
         act = classify_op(8'(op), 8'(OP_SET_MODE), 8'(OP_TRACE));
      else
         act = ACT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_RST;
         trace_en   <= 1'b0;
         cmd_strobe <= 1'b0;
         cmd_code   <= '0;
         cmd_data   <= '0;
      end else begin
         cmd_strobe <= 1'b0;
         unique case (act)
            ACT_MODE:  mode_q   <= payload;
            ACT_TRACE: trace_en <= payload[0];
            ACT_PASS: begin
               cmd_strobe <= 1'b1;
               cmd_code   <= op;
               cmd_data   <= payload;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/spi_cmd_rx.sv
`timescale 1ns/1ps
module spi_cmd_rx #(
   parameter int                CMD_W       = 4,
   parameter int                DATA_W      = 12,
   parameter int                SYNC_STAGES = 2,
   parameter logic [CMD_W-1:0]  OP_SET_MODE = 4'h1,
   parameter logic [CMD_W-1:0]  OP_TRACE    = 4'h2,
   parameter logic [DATA_W-1:0] MODE_RST    = '0,
   localparam int FRAME_W = CMD_W + DATA_W,
   localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   output logic [DATA_W-1:0] mode_q,
   output logic              trace_en,
   output logic              cmd_strobe,
   output logic [CMD_W-1:0]  cmd_code,
   output logic [DATA_W-1:0] cmd_data
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_cmd_rx: SYNC_STAGES must be at least 2");
   end
   if (CMD_W < 1 || CMD_W > 8 || DATA_W < 1) begin : g_bad_width
      $error("spi_cmd_rx: CMD_W must be 1..8 and DATA_W at least 1");
   end
   if (OP_SET_MODE == OP_TRACE) begin : g_bad_ops
      $error("spi_cmd_rx: the two register opcodes must differ");
   end

   logic [2:0]         pins_s;
   logic               frm_valid;
   logic [FRAME_W-1:0] frm_word;
   logic [CNT_W-1:0]   bit_cnt;

   spi_cmd_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({spi_cs_n, spi_sck, spi_mosi}),
      .sync_o  (pins_s)
   );

   spi_cmd_framer #(
      .FRAME_W (FRAME_W)
   ) framer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (pins_s[2]),
      .sck_s     (pins_s[1]),
      .mosi_s    (pins_s[0]),
      .frm_valid (frm_valid),
      .frm_word  (frm_word),
      .bit_cnt   (bit_cnt)
   );

   spi_cmd_decode #(
      .CMD_W       (CMD_W),
      .DATA_W      (DATA_W),
      .OP_SET_MODE (OP_SET_MODE),
      .OP_TRACE    (OP_TRACE),
      .MODE_RST    (MODE_RST)
   ) decode_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .frm_valid  (frm_valid),
      .frm_word   (frm_word),
      .mode_q     (mode_q),
      .trace_en   (trace_en),
      .cmd_strobe (cmd_strobe),
      .cmd_code   (cmd_code),
      .cmd_data   (cmd_data)
   );

endmodule

// File: rtl/spi_cmd_rx_chk.sv
`timescale 1ns/1ps
module spi_cmd_rx_chk #(
   parameter int               CMD_W       = 4,
   parameter int               DATA_W      = 12,
   parameter logic [CMD_W-1:0] OP_SET_MODE = 4'h1,
   parameter logic [CMD_W-1:0] OP_TRACE    = 4'h2,
   localparam int FRAME_W = CMD_W + DATA_W,
   localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_valid,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic [DATA_W-1:0] mode_q,
   input logic              trace_en,
   input logic              cmd_strobe,
   input logic [CMD_W-1:0]  cmd_code
);

   // R3: a frame is only accepted when the count stood at exactly FRAME_W
   a_r3_full_count_only: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> $past(bit_cnt) == CNT_W'(FRAME_W));

   // R3: the bit counter saturates one past a full frame
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W + 1));

   // R4: the mode register moves only after an accepted frame
   a_r4_mode_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> $past(frm_valid));

   // R5: the trace flag moves only after an accepted frame
   a_r5_trace_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(trace_en) |-> $past(frm_valid));

   // R6: the strobe lasts a single cycle
   a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe |=> !cmd_strobe);

   // R6: the strobe never carries a register opcode
   a_r6_strobe_code: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe |-> (cmd_code != OP_SET_MODE && cmd_code != OP_TRACE));

   // R6: a strobe leaves both registers untouched
   a_r6_strobe_no_reg: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_strobe) |-> ($stable(mode_q) && $stable(trace_en)));

endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(
   .CMD_W       (CMD_W),
   .DATA_W      (DATA_W),
   .OP_SET_MODE (OP_SET_MODE),
   .OP_TRACE    (OP_TRACE)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .frm_valid  (frm_valid),
   .bit_cnt    (bit_cnt),
   .mode_q     (mode_q),
   .trace_en   (trace_en),
   .cmd_strobe (cmd_strobe),
   .cmd_code   (cmd_code)
);

// File: tb/spi_cmd_rx_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_rx_tb_top;

   localparam int HALF = 8;   // system clocks per serial half period

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_sck = 1'b0;
   logic        spi_mosi = 1'b0;
   logic [11:0] mode_q;
   logic        trace_en;
   logic        cmd_strobe;
   logic [3:0]  cmd_code;
   logic [11:0] cmd_data;

   int n_cmp = 0;
   int n_bad = 0;
   int strobe_cnt = 0;
   logic [3:0]  seen_code = '0;
   logic [11:0] seen_data = '0;
   int cycles = 0;
   bit done = 1'b0;

   logic [11:0] exp_mode = '0;
   logic        exp_trace = 1'b0;
   int          exp_strobes = 0;

   always #2 clk = ~clk;

   spi_cmd_rx dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_cs_n   (spi_cs_n),
      .spi_sck    (spi_sck),
      .spi_mosi   (spi_mosi),
      .mode_q     (mode_q),
      .trace_en   (trace_en),
      .cmd_strobe (cmd_strobe),
      .cmd_code   (cmd_code),
      .cmd_data   (cmd_data)
   );

   always @(negedge clk) begin
      cycles <= cycles + 1;
      if (cmd_strobe) begin
         strobe_cnt <= strobe_cnt + 1;
         seen_code  <= cmd_code;
         seen_data  <= cmd_data;
      end
   end

   always @(negedge clk) begin
      if (!done && cycles > 150000) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // send nbits taken from the low end of pattern, most significant first
   task automatic send_bits(input int nbits, input logic [31:0] pattern);
      spi_cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = nbits - 1; i >= 0; i--) begin
         spi_mosi = pattern[i];
         wait_clk(HALF);
         spi_sck = 1'b1;
         wait_clk(HALF);
         spi_sck = 1'b0;
      end
      wait_clk(HALF);
      spi_cs_n = 1'b1;
      wait_clk(6);
   endtask

   task automatic check_state(input string req);
      check({req, " mode"}, 32'(mode_q), 32'(exp_mode));
      check({req, " trace"}, 32'(trace_en), 32'(exp_trace));
      check({req, " strobes"}, 32'(strobe_cnt), 32'(exp_strobes));
   endtask

   initial begin
      logic [11:0] pays [4];
      pays[0] = 12'h000; pays[1] = 12'h001; pays[2] = 12'hA5C; pays[3] = 12'hFFF;

      wait_clk(3);
      // R1: reset values
      check("R1 mode", 32'(mode_q), 32'h0);
      check("R1 trace", 32'(trace_en), 32'h0);
      check("R1 strobe", 32'(cmd_strobe), 32'h0);
      rst_n = 1'b1;
      wait_clk(4);
      check_state("R1");

      // R2 R4 R5 R6: every opcode against several payloads
      for (int op = 0; op < 16; op++) begin
         for (int p = 0; p < 4; p++) begin
            send_bits(16, {16'h0, op[3:0], pays[p]});
            if (op == 1) exp_mode = pays[p];
            else if (op == 2) exp_trace = pays[p][0];
            else exp_strobes++;
            check_state(op == 1 ? "R4" : (op == 2 ? "R5" : "R6"));
            if (op != 1 && op != 2) begin
               check("R6 R2 code", 32'(seen_code), 32'(op));
               check("R6 R2 data", 32'(seen_data), 32'(pays[p]));
            end
         end
      end

      // R4: load a known mode, then R3 wrong lengths must leave it
      send_bits(16, 32'h0000_1123);
      exp_mode = 12'h123;
      check_state("R4 preset");
      send_bits(16, 32'h0000_2001);
      exp_trace = 1'b1;
      check_state("R5 preset");
      foreach (pays[k]) begin end
      for (int li = 0; li < 8; li++) begin
         int lens [8] = '{0, 1, 4, 12, 15, 17, 20, 31};
         send_bits(lens[li], 32'h1E7E_1E7E);
         check_state("R3 mode-word length");
         send_bits(lens[li], 32'h2000_2000);
         check_state("R3 trace-word length");
         send_bits(lens[li], 32'h5ABC_5ABC);
         check_state("R3 pass-word length");
      end

      // R7: stray serial clock edges while deselected, then a full frame
      for (int s = 0; s < 5; s++) begin
         spi_mosi = 1'b1;
         wait_clk(HALF);
         spi_sck = 1'b1;
         wait_clk(HALF);
         spi_sck = 1'b0;
      end
      spi_mosi = 1'b0;
      wait_clk(HALF);
      send_bits(16, 32'h0000_15A5);
      exp_mode = 12'h5A5;
      check_state("R7");

      // R5: trace follows payload bit 0 only
      send_bits(16, 32'h0000_2FFE);
      exp_trace = 1'b0;
      check_state("R5 bit0");

      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule